// File: doc/BRIEF.md
# USB Endpoint Interrupt Aggregator

This block gathers interrupt events for a USB dual-role controller and combines them into one active-low interrupt line for the CPU. The endpoint and bus logic signal an event with a single-cycle pulse. There are three groups of events. The first group is transmit events: endpoint 0 plus transmit endpoints 1 to 15. The second group is receive events for receive endpoints 1 to 15. The third group is eight bus-level USB events. Each group has a status register and an enable register. A status bit latches on its event whatever the state of its enable bit. The interrupt line only counts status bits whose enable bit is set.

The CPU uses a byte-addressed read/write port. A read returns the register contents in the same cycle, and the clock edge that ends the read carries out any clearing. Reading the low byte of a 16-bit status register, or reading the 8-bit event status register, clears the whole register. The data returned is the value from before the clear. Two 16-bit parameters select the transmit and receive endpoints that are built. Bits of endpoints that are not built stay zero in the status and enable registers.

Top module: `usb_irq_hub`

## Requirements
- R1: After reset all status registers read 0, irqN is 1, and the enable registers read as follows: transmit enable = the implemented transmit mask, receive enable = the implemented receive mask, event enable = 8'h06.
- R2: An event pulse on an implemented bit sets the matching status bit on the next clock edge, even when that bit's enable is 0.
- R3: irqN is 0 while at least one status bit and its enable bit are both 1, and irqN is 1 at all other times.
- R4: Reading offset 2 (transmit low byte) or offset 4 (receive low byte) returns the bits from before the clear and clears all 16 bits of that status register. Reading offset 3 or 5 (high byte) returns bits 15:8 and clears nothing.
- R5: Reading offset 0xA returns the 8-bit event status and clears it. Offset 0xB is the event enable register, which can be read and written.
- R6: Transmit bit 0 (endpoint 0) always exists. Receive bit 0 always reads 0. A bit that IMPL_TX_MASK or IMPL_RX_MASK leaves clear reads 0 in status and in enable, whatever events or writes it receives.
- R7: If an event pulse arrives in the same cycle as a clearing read of its register, that bit is still set after the read.
- R8: Writes to the status offsets (2, 3, 4, 5, 0xA) change nothing. The enable registers are written one byte lane at a time: offsets 6/7 are transmit enable low/high, and offsets 8/9 are receive enable low/high.
- R9: Reading any unused offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txEvt | input | 16 | One-cycle transmit event pulses, bit 0 = endpoint 0 |
| rxEvt | input | 16 | One-cycle receive event pulses, bit n = receive endpoint n |
| busEvt | input | 8 | One-cycle USB bus event pulses |
| cpuAddr | input | 4 | Byte offset of the register |
| cpuRd | input | 1 | Read strobe; a low-byte status read clears the register at the clock edge |
| cpuWr | input | 1 | Write strobe |
| cpuWdata | input | 8 | Write data |
| cpuRdata | output | 8 | Read data for cpuAddr, valid in the same cycle |
| irqN | output | 1 | Interrupt request, active low |

## Verification
Two things can happen on the same clock edge: a clearing read of a status register, and a new event pulse for a bit in that register. The bench starts a low-byte read and, in that same cycle, drives an event on a bit that is already pending and on a bit that was not yet set. It checks three things. The read data must show only the old contents. A second read must show that both event bits survived. The irqN line must stay asserted. The event status register gets the same treatment.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_TX_LO    = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_TX_HI    = 4'h3;
  localparam logic [ADDR_W-1:0] OFS_RX_LO    = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_RX_HI    = 4'h5;
  localparam logic [ADDR_W-1:0] OFS_TXEN_LO  = 4'h6;
  localparam logic [ADDR_W-1:0] OFS_TXEN_HI  = 4'h7;
  localparam logic [ADDR_W-1:0] OFS_RXEN_LO  = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_RXEN_HI  = 4'h9;
  localparam logic [ADDR_W-1:0] OFS_BUS_STAT = 4'hA;
  localparam logic [ADDR_W-1:0] OFS_BUS_EN   = 4'hB;

  localparam logic [7:0] BUS_EN_RESET = 8'h06;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TX,
    SEL_RX,
    SEL_BUS,
    SEL_TXEN,
    SEL_RXEN,
    SEL_BUSEN
  } rdSel_t;

  typedef struct packed {
    logic       clrTx;
    logic       clrRx;
    logic       clrBus;
    logic [1:0] wrTxEn;
    logic [1:0] wrRxEn;
    logic       wrBusEn;
    rdSel_t     rdSel;
    logic       rdHi;
  } irqStrobes_t;

endpackage

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl
  import usb_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  output irqStrobes_t       strb
);

  always_comb begin
    strb = '0;
    strb.rdSel = SEL_NONE;
    unique case (cpuAddr)
      OFS_TX_LO: begin
        strb.rdSel = SEL_TX;
        strb.clrTx = cpuRd;
      end
      OFS_TX_HI: begin
        strb.rdSel = SEL_TX;
        strb.rdHi  = 1'b1;
      end
      OFS_RX_LO: begin
        strb.rdSel = SEL_RX;
        strb.clrRx = cpuRd;
      end
      OFS_RX_HI: begin
        strb.rdSel = SEL_RX;
        strb.rdHi  = 1'b1;
      end
      OFS_TXEN_LO: begin
        strb.rdSel     = SEL_TXEN;
        strb.wrTxEn[0] = cpuWr;
      end
      OFS_TXEN_HI: begin
        strb.rdSel     = SEL_TXEN;
        strb.rdHi      = 1'b1;
        strb.wrTxEn[1] = cpuWr;
      end
      OFS_RXEN_LO: begin
        strb.rdSel     = SEL_RXEN;
        strb.wrRxEn[0] = cpuWr;
      end
      OFS_RXEN_HI: begin
        strb.rdSel     = SEL_RXEN;
        strb.rdHi      = 1'b1;
        strb.wrRxEn[1] = cpuWr;
      end
      OFS_BUS_STAT: begin
        strb.rdSel  = SEL_BUS;
        strb.clrBus = cpuRd;
      end
      OFS_BUS_EN: begin
        strb.rdSel   = SEL_BUSEN;
        strb.wrBusEn = cpuWr;
      end
      default: strb.rdSel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/usb_irq_bank.sv
module usb_irq_bank #(
  parameter int             W      = 16,
  parameter logic [W-1:0]   IMPL   = '1,
  parameter logic [W-1:0]   EN_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     evt,
  input  logic             clr,
  input  logic [W/8-1:0]   wrLane,
  input  logic [7:0]       wdata,
  output logic [W-1:0]     stat,
  output logic [W-1:0]     en
);

  localparam int LANES = W / 8;

  logic [W-1:0] evtLive;
  logic [W-1:0] statKeep;

  assign evtLive  = evt & IMPL;
  assign statKeep = clr ? '0 : stat;

  // A pulse arriving with the clear wins over the clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= statKeep | evtLive;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         en[l*8 +: 8] <= EN_RST[l*8 +: 8] & IMPL[l*8 +: 8];
      else if (wrLane[l]) en[l*8 +: 8] <= wdata & IMPL[l*8 +: 8];
    end
  end

endmodule

// File: rtl/usb_irq_dp.sv
module usb_irq_dp
  import usb_irq_pkg::*;
#(
  parameter logic [15:0] TX_IMPL = 16'h0001,
  parameter logic [15:0] RX_IMPL = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] txEvt,
  input  logic [15:0] rxEvt,
  input  logic [7:0]  busEvt,
  input  logic [7:0]  cpuWdata,
  input  irqStrobes_t strb,
  output logic [7:0]  cpuRdata,
  output logic        irqN,
  output logic [15:0] txStat,
  output logic [15:0] rxStat,
  output logic [7:0]  busStat,
  output logic [15:0] txEn,
  output logic [15:0] rxEn,
  output logic [7:0]  busEn
);

  usb_irq_bank #(.W(16), .IMPL(TX_IMPL), .EN_RST(16'hFFFF)) u_txBank (
    .clk(clk), .rst_n(rst_n), .evt(txEvt), .clr(strb.clrTx),
    .wrLane(strb.wrTxEn), .wdata(cpuWdata), .stat(txStat), .en(txEn)
  );

  usb_irq_bank #(.W(16), .IMPL(RX_IMPL), .EN_RST(16'hFFFE)) u_rxBank (
    .clk(clk), .rst_n(rst_n), .evt(rxEvt), .clr(strb.clrRx),
    .wrLane(strb.wrRxEn), .wdata(cpuWdata), .stat(rxStat), .en(rxEn)
  );

  usb_irq_bank #(.W(8), .IMPL(8'hFF), .EN_RST(BUS_EN_RESET)) u_busBank (
    .clk(clk), .rst_n(rst_n), .evt(busEvt), .clr(strb.clrBus),
    .wrLane(strb.wrBusEn), .wdata(cpuWdata), .stat(busStat), .en(busEn)
  );

  logic [15:0] rdWord;

  always_comb begin
    unique case (strb.rdSel)
      SEL_TX:    rdWord = txStat;
      SEL_RX:    rdWord = rxStat;
      SEL_BUS:   rdWord = {8'h00, busStat};
      SEL_TXEN:  rdWord = txEn;
      SEL_RXEN:  rdWord = rxEn;
      SEL_BUSEN: rdWord = {8'h00, busEn};
      default:   rdWord = 16'h0000;
    endcase
  end

  assign cpuRdata = strb.rdHi ? rdWord[15:8] : rdWord[7:0];

  logic anyPending;
  assign anyPending = |(txStat & txEn) | |(rxStat & rxEn) | |(busStat & busEn);
  assign irqN       = ~anyPending;

endmodule

// File: rtl/usb_irq_hub.sv
module usb_irq_hub
  import usb_irq_pkg::*;
#(
  parameter logic [15:0] IMPL_TX_MASK = 16'h0C1F,
  parameter logic [15:0] IMPL_RX_MASK = 16'h800E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       txEvt,
  input  logic [15:0]       rxEvt,
  input  logic [7:0]        busEvt,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [7:0]        cpuWdata,
  output logic [7:0]        cpuRdata,
  output logic              irqN
);

  localparam logic [15:0] TX_IMPL = IMPL_TX_MASK | 16'h0001;
  localparam logic [15:0] RX_IMPL = IMPL_RX_MASK & 16'hFFFE;

  irqStrobes_t strb;
  logic [15:0] txStat, rxStat, txEn, rxEn;
  logic [7:0]  busStat, busEn;

  usb_irq_ctrl u_ctrl (
    .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr), .strb(strb)
  );

  usb_irq_dp #(.TX_IMPL(TX_IMPL), .RX_IMPL(RX_IMPL)) u_dp (
    .clk(clk), .rst_n(rst_n), .txEvt(txEvt), .rxEvt(rxEvt), .busEvt(busEvt),
    .cpuWdata(cpuWdata), .strb(strb), .cpuRdata(cpuRdata), .irqN(irqN),
    .txStat(txStat), .rxStat(rxStat), .busStat(busStat),
    .txEn(txEn), .rxEn(rxEn), .busEn(busEn)
  );

endmodule

// File: rtl/usb_irq_chk.sv
module usb_irq_chk
  import usb_irq_pkg::*;
#(
  parameter logic [15:0] TX_IMPL = 16'h0001,
  parameter logic [15:0] RX_IMPL = 16'h0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       txEvt,
  input logic [7:0]        busEvt,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              cpuRd,
  input logic              cpuWr,
  input logic              irqN,
  input logic [15:0]       txStat,
  input logic [15:0]       rxStat,
  input logic [7:0]        busStat,
  input logic [15:0]       rxEn,
  input logic [7:0]        busEn
);

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (txStat == 16'h0 && rxStat == 16'h0 && busStat == 8'h0) |-> irqN);

  assert_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busEvt != 8'h0) |=> ((busStat & $past(busEvt)) == $past(busEvt)));

  assert_irq_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(busEvt & busEn)) && !cpuWr) |=> !irqN);

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuRd && cpuAddr == OFS_TX_LO && txEvt == 16'h0) |=> (txStat == 16'h0));

  assert_unimpl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((txStat & ~TX_IMPL) == 16'h0) && ((rxStat & ~RX_IMPL) == 16'h0)
    && ((rxEn & ~RX_IMPL) == 16'h0));

  assert_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuRd && cpuAddr == OFS_TX_LO && (txEvt & TX_IMPL) != 16'h0)
    |=> ((txStat & $past(txEvt & TX_IMPL)) == $past(txEvt & TX_IMPL)));

endmodule

bind usb_irq_hub usb_irq_chk #(.TX_IMPL(TX_IMPL), .RX_IMPL(RX_IMPL)) u_chk (
  .clk(clk), .rst_n(rst_n), .txEvt(txEvt), .busEvt(busEvt),
  .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr), .irqN(irqN),
  .txStat(txStat), .rxStat(rxStat), .busStat(busStat),
  .rxEn(rxEn), .busEn(busEn)
);

// File: tb/sim_usb_irq_hub.sv
`timescale 1ns/1ps
module sim_usb_irq_hub;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] txEvt = '0;
  logic [15:0] rxEvt = '0;
  logic [7:0]  busEvt = '0;
  logic [3:0]  cpuAddr = '0;
  logic        cpuRd = 1'b0;
  logic        cpuWr = 1'b0;
  logic [7:0]  cpuWdata = '0;
  logic [7:0]  cpuRdata;
  logic        irqN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  usb_irq_hub #(.IMPL_TX_MASK(16'h0C1F), .IMPL_RX_MASK(16'h800E)) u0 (
    .clk(clk), .rst_n(rst_n), .txEvt(txEvt), .rxEvt(rxEvt), .busEvt(busEvt),
    .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .irqN(irqN)
  );

  task automatic check(string req, string what, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic pulse(logic [15:0] tx, logic [15:0] rx, logic [7:0] bus);
    @(negedge clk);
    txEvt = tx; rxEvt = rx; busEvt = bus;
    @(negedge clk);
    txEvt = '0; rxEvt = '0; busEvt = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuRd = 1'b1;
    #1 d = cpuRdata;
    @(negedge clk);
    cpuRd = 1'b0;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] v);
    @(negedge clk);
    cpuAddr = a; cpuWr = 1'b1; cpuWdata = v;
    @(negedge clk);
    cpuWr = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1", "irqN after reset", 16'(irqN), 16'h1);
    rd(4'h6, d); check("R1", "tx enable lo", 16'(d), 16'h1F);
    rd(4'h7, d); check("R1", "tx enable hi", 16'(d), 16'h0C);
    rd(4'h8, d); check("R1", "rx enable lo", 16'(d), 16'h0E);
    rd(4'h9, d); check("R1", "rx enable hi", 16'(d), 16'h80);
    rd(4'hB, d); check("R1", "bus enable", 16'(d), 16'h06);
    rd(4'h2, d); check("R1", "tx status", 16'(d), 16'h00);
    rd(4'hA, d); check("R1", "bus status", 16'(d), 16'h00);
    rd(4'h1, d); check("R9", "unused offset 1", 16'(d), 16'h00);
    rd(4'hC, d); check("R9", "unused offset C", 16'(d), 16'h00);
  endtask

  task automatic t_latch_disabled();
    logic [7:0] d;
    wr(4'h6, 8'h00);
    pulse(16'h0004, '0, '0);
    check("R2", "irqN with disabled bit", 16'(irqN), 16'h1);
    rd(4'h2, d); check("R2", "disabled bit latched", 16'(d), 16'h04);
    rd(4'h2, d); check("R4", "cleared after read", 16'(d), 16'h00);
    wr(4'h6, 8'hFF);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    pulse(16'h0002, '0, '0);
    check("R3", "irqN asserted", 16'(irqN), 16'h0);
    rd(4'h2, d); check("R4", "tx lo value", 16'(d), 16'h02);
    check("R3", "irqN released after clear", 16'(irqN), 16'h1);
    pulse('0, 16'h8002, '0);
    check("R3", "irqN from rx", 16'(irqN), 16'h0);
    rd(4'h5, d); check("R4", "rx hi value", 16'(d), 16'h80);
    rd(4'h4, d); check("R4", "rx lo value", 16'(d), 16'h02);
    rd(4'h5, d); check("R4", "rx hi cleared by lo read", 16'(d), 16'h00);
    check("R3", "irqN released rx", 16'(irqN), 16'h1);
  endtask

  task automatic t_hi_no_clear();
    logic [7:0] d;
    pulse(16'h0401, '0, '0);
    rd(4'h3, d); check("R4", "hi read", 16'(d), 16'h04);
    check("R4", "irqN held after hi read", 16'(irqN), 16'h0);
    rd(4'h3, d); check("R4", "hi read again", 16'(d), 16'h04);
    rd(4'h2, d); check("R4", "lo read", 16'(d), 16'h01);
    rd(4'h3, d); check("R4", "hi cleared", 16'(d), 16'h00);
  endtask

  task automatic t_unimpl();
    logic [7:0] d;
    pulse(16'hFFFF, 16'hFFFF, '0);
    rd(4'h3, d); check("R6", "tx hi impl only", 16'(d), 16'h0C);
    rd(4'h2, d); check("R6", "tx lo impl only", 16'(d), 16'h1F);
    rd(4'h5, d); check("R6", "rx hi impl only", 16'(d), 16'h80);
    rd(4'h4, d); check("R6", "rx lo impl, bit0 zero", 16'(d), 16'h0E);
    pulse('0, 16'h0001, '0);
    rd(4'h4, d); check("R6", "rx bit0 never sets", 16'(d), 16'h00);
    check("R6", "irqN after rx bit0 pulse", 16'(irqN), 16'h1);
    wr(4'h7, 8'hFF); rd(4'h7, d); check("R6", "tx en hi masked", 16'(d), 16'h0C);
    wr(4'h8, 8'hFF); rd(4'h8, d); check("R6", "rx en lo masked", 16'(d), 16'h0E);
  endtask

  task automatic t_bus();
    logic [7:0] d;
    pulse('0, '0, 8'h01);
    check("R5", "bus bit0 disabled no irq", 16'(irqN), 16'h1);
    pulse('0, '0, 8'h02);
    check("R5", "bus bit1 irq", 16'(irqN), 16'h0);
    rd(4'hA, d); check("R5", "bus status", 16'(d), 16'h03);
    rd(4'hA, d); check("R5", "bus cleared", 16'(d), 16'h00);
    check("R5", "irqN released", 16'(irqN), 16'h1);
    wr(4'hB, 8'h81); rd(4'hB, d); check("R5", "bus enable write", 16'(d), 16'h81);
    pulse('0, '0, 8'h01);
    check("R5", "bus bit0 enabled irq", 16'(irqN), 16'h0);
    rd(4'hA, d);
    wr(4'hB, 8'h06);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    pulse(16'h0008, '0, '0);
    @(negedge clk);
    cpuAddr = 4'h2; cpuRd = 1'b1; txEvt = 16'h0018;
    #1 d = cpuRdata;
    @(negedge clk);
    cpuRd = 1'b0; txEvt = '0;
    check("R7", "read shows old value", 16'(d), 16'h08);
    check("R7", "irqN still low", 16'(irqN), 16'h0);
    rd(4'h2, d); check("R7", "both bits survive", 16'(d), 16'h18);
    pulse('0, '0, 8'h04);
    @(negedge clk);
    cpuAddr = 4'hA; cpuRd = 1'b1; busEvt = 8'h40;
    #1 d = cpuRdata;
    @(negedge clk);
    cpuRd = 1'b0; busEvt = '0;
    check("R7", "bus read old value", 16'(d), 16'h04);
    rd(4'hA, d); check("R7", "bus new bit survives", 16'(d), 16'h40);
  endtask

  task automatic t_status_write();
    logic [7:0] d;
    pulse(16'h0002, '0, 8'h02);
    wr(4'h2, 8'h00); wr(4'h3, 8'hFF); wr(4'hA, 8'h00);
    rd(4'h3, d); check("R8", "tx hi untouched by write", 16'(d), 16'h00);
    rd(4'h2, d); check("R8", "tx lo untouched by write", 16'(d), 16'h02);
    rd(4'hA, d); check("R8", "bus untouched by write", 16'(d), 16'h02);
    wr(4'h9, 8'h00); rd(4'h9, d); check("R8", "rx en hi lane", 16'(d), 16'h00);
    rd(4'h8, d); check("R8", "rx en lo lane kept", 16'(d), 16'h0E);
    wr(4'h6, 8'h00); wr(4'h7, 8'h00); wr(4'h8, 8'h00); wr(4'hB, 8'h00);
    pulse(16'h0C1F, 16'h800E, 8'hFF);
    check("R3", "all disabled irqN high", 16'(irqN), 16'h1);
    wr(4'h7, 8'h08);
    check("R3", "enable raises irq", 16'(irqN), 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch_disabled();
    t_irq();
    t_hi_no_clear();
    t_unimpl();
    t_bus();
    t_collide();
    t_status_write();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule